// File: doc/BRIEF.md
# Port Bypass Control and Status Register

This block is one addressable byte register that steers a single port-bypass circuit through two pins. One pin is a push-pull force-bypass output: a 1 puts the bypass circuit into normal mode, a 0 puts it into bypass mode. The other pin is a signal-detect input from the bypass circuit. That input passes through a two-flop synchronizer and a glitch filter before anything inside the block uses it.

The host reaches the register through a simple strobe interface. `wrEn` or `rdEn` is raised for one cycle together with an address. Read data is combinational in the same cycle. The register holds:
- an enable bit, which hands both pins over to the bypass function;
- an interrupt-enable bit;
- a force-bypass bit;
- a read-only bit that reflects the filtered signal-detect level.

When the filtered signal-detect level is low, hardware clears the force-bypass bit. The bypass circuit therefore drops into bypass mode soon after the high-speed signal is lost, with no host involvement. Each filtered signal-detect edge can raise an active-low interrupt. It also loads this register's own address into a companion interrupt-source register. Reading that source register acknowledges the interrupt.

Top module: `bypass_ctl_reg`

## Requirements
- R1: After reset, with the signal-detect pin held high, the control register reads 0x03, the source register reads 0x00, `intN` is 1, and both `fbOe` and `fbPin` are 0.
- R2: The control register sits at address 0x25. Bit 7 (enable), bit 6 (interrupt enable) and bit 1 (force bypass) are writable. Bits 5..2 read 0. Writes to any other address leave the register unchanged.
- R3: `fbOe` equals the enable bit. `fbPin` equals the force-bypass bit while enable is 1 and is 0 while enable is 0.
- R4: Bit 0 returns the filtered signal-detect level, and host writes to bit 0 have no effect. The filtered level changes only after 4 consecutive synchronized samples that differ from it, so a pin pulse of 3 cycles or fewer is ignored.
- R5: After the pin falls with enable and force bypass both at 1, `fbPin` stays 1 for at least 5 clock cycles. It is 0 within 8 cycles, which is 32 ns at 250 MHz and well inside the 400 ns budget.
- R6: While the filtered level is low, the force-bypass bit is held at 0. A host write of 1 to it in that state loses, and the bit reads back 0.
- R7: With interrupt enable at 1, every rising or falling filtered edge drives `intN` to 0 and loads 0x25 into the source register. With interrupt enable at 0, edges raise no interrupt.
- R8: A read of the source register at address 0x26 returns its value, then clears it to 0x00 and releases `intN` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle |
| rdEn | input | 1 | Read strobe, one cycle; a source read clears it |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the strobe cycle; 0 when no register is selected |
| sdPin | input | 1 | Asynchronous signal-detect pin |
| fbPin | output | 1 | Force-bypass pin value (1 = normal, 0 = bypass) |
| fbOe | output | 1 | Force-bypass pin output enable |
| intN | output | 1 | Active-low interrupt |

## Verification
A stuck or mis-sequenced filter counter shows at the ports in one of two ways. A short pin pulse may get through to bit 0, to `fbPin` and to `intN` within about ten cycles. Or a real loss of signal may fail to pull `fbPin` low inside the 8-cycle window. A lost interrupt or a wrong source value shows as soon as the next source read. A wrong priority between the host write and the automatic clear shows on the next control-register read. The bench mixes seeded random writes, pin glitches, long pin toggles and source reads. After each step it compares every port against a model of the register state.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef struct packed {
    logic wrCtl;
    logic rdCtl;
    logic rdSrc;
    logic sdChg;
  } bpcStrobe_t;
endpackage

// File: rtl/bpc_sd_filter.sv
module bpc_sd_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdPin,
  output logic filtLevel,
  output logic sdChg
);
  localparam int CW = $clog2(FILT_LEN) + 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0] runCnt;
  logic syncOut;

  // Pin powers up pulled high, so the chain resets to 1.
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdPin};
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  // Count consecutive samples that disagree with the held level.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtLevel <= 1'b1;
      runCnt    <= '0;
      sdChg     <= 1'b0;
    end else if (syncOut == filtLevel) begin
      runCnt <= '0;
      sdChg  <= 1'b0;
    end else if (runCnt == LAST) begin
      filtLevel <= syncOut;
      runCnt    <= '0;
      sdChg     <= 1'b1;
    end else begin
      runCnt <= runCnt + 1'b1;
      sdChg  <= 1'b0;
    end
  end
endmodule

// File: rtl/bpc_ctrl.sv
module bpc_ctrl import bpc_pkg::*; #(
  parameter int AW = 8,
  parameter logic [AW-1:0] REG_ADDR = 'h25,
  parameter logic [AW-1:0] SRC_ADDR = 'h26
) (
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic          sdChg,
  output bpcStrobe_t    strobe
);
  logic hitCtl;
  logic hitSrc;

  assign hitCtl = (addr == REG_ADDR);
  assign hitSrc = (addr == SRC_ADDR);

  always_comb begin
    strobe.wrCtl = wrEn && hitCtl;
    strobe.rdCtl = rdEn && hitCtl;
    strobe.rdSrc = rdEn && hitSrc;
    strobe.sdChg = sdChg;
  end
endmodule

// File: rtl/bpc_datapath.sv
module bpc_datapath import bpc_pkg::*; #(
  parameter int DW = 8,
  parameter logic [DW-1:0] SRC_CODE = 'h25
) (
  input  logic          clk,
  input  logic          rstN,
  input  bpcStrobe_t    strobe,
  input  logic [DW-1:0] wrData,
  input  logic          filtLevel,
  output logic [DW-1:0] rdData,
  output logic          fbPin,
  output logic          fbOe,
  output logic          intN
);
  localparam int EN_BIT = DW - 1;
  localparam int IE_BIT = DW - 2;
  localparam int FB_BIT = 1;
  localparam int SD_BIT = 0;

  logic ctlEn;
  logic intEn;
  logic fbBit;
  logic intPend;
  logic [DW-1:0] srcVal;
  logic [DW-1:0] ctlImage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlEn <= 1'b0;
      intEn <= 1'b0;
    end else if (strobe.wrCtl) begin
      ctlEn <= wrData[EN_BIT];
      intEn <= wrData[IE_BIT];
    end
  end

  // Loss of signal outranks a host write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)           fbBit <= 1'b1;
    else if (!filtLevel) fbBit <= 1'b0;
    else if (strobe.wrCtl) fbBit <= wrData[FB_BIT];
  end

  // A new event outranks the acknowledging read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intPend <= 1'b0;
      srcVal  <= '0;
    end else if (strobe.sdChg && intEn) begin
      intPend <= 1'b1;
      srcVal  <= SRC_CODE;
    end else if (strobe.rdSrc) begin
      intPend <= 1'b0;
      srcVal  <= '0;
    end
  end

  always_comb begin
    ctlImage         = '0;
    ctlImage[EN_BIT] = ctlEn;
    ctlImage[IE_BIT] = intEn;
    ctlImage[FB_BIT] = fbBit;
    ctlImage[SD_BIT] = filtLevel;
    if (strobe.rdCtl)      rdData = ctlImage;
    else if (strobe.rdSrc) rdData = srcVal;
    else                   rdData = '0;
  end

  assign fbOe  = ctlEn;
  assign fbPin = ctlEn & fbBit;
  assign intN  = ~intPend;
endmodule

// File: rtl/bypass_ctl_reg.sv
module bypass_ctl_reg import bpc_pkg::*; #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter logic [AW-1:0] REG_ADDR = 'h25,
  parameter logic [AW-1:0] SRC_ADDR = 'h26,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic          sdPin,
  output logic          fbPin,
  output logic          fbOe,
  output logic          intN
);
  localparam logic [DW-1:0] SRC_CODE = DW'(REG_ADDR);

  logic filtLevel;
  logic sdChg;
  bpcStrobe_t strobe;

  bpc_sd_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rstN(rstN), .sdPin(sdPin), .filtLevel(filtLevel), .sdChg(sdChg)
  );

  bpc_ctrl #(.AW(AW), .REG_ADDR(REG_ADDR), .SRC_ADDR(SRC_ADDR)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .sdChg(sdChg), .strobe(strobe)
  );

  bpc_datapath #(.DW(DW), .SRC_CODE(SRC_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .filtLevel(filtLevel),
    .rdData(rdData), .fbPin(fbPin), .fbOe(fbOe), .intN(intN)
  );
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG_ADDR = 'h25,
  parameter logic [AW-1:0] SRC_ADDR = 'h26
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          rdEn,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wrData,
  input logic          fbPin,
  input logic          fbOe,
  input logic          intN,
  input logic          filtLevel,
  input logic          sdChg
);
  assert_wr_fb_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_ADDR && wrData[DW-1] && filtLevel)
      |=> (fbOe && fbPin == $past(wrData[1])));

  assert_disable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_ADDR && !wrData[DW-1]) |=> (!fbOe && !fbPin));

  assert_autoclr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fbOe && !filtLevel) |=> !fbPin);

  assert_int_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(sdChg));

  assert_src_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == SRC_ADDR && !sdChg) |=> intN);
endmodule

bind bypass_ctl_reg bpc_checker #(
  .AW(AW), .DW(DW), .REG_ADDR(REG_ADDR), .SRC_ADDR(SRC_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .fbPin(fbPin), .fbOe(fbOe), .intN(intN), .filtLevel(filtLevel), .sdChg(sdChg)
);

// File: tb/sim_bypass_ctl_reg.sv
module sim_bypass_ctl_reg;
  localparam logic [7:0] REG_A = 8'h25;
  localparam logic [7:0] SRC_A = 8'h26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic sdPin = 1'b1;
  logic fbPin, fbOe, intN;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;

  logic mEn = 0, mIe = 0, mFb = 1, mLvl = 1, mPend = 0;

  always #2 clk = ~clk;

  bypass_ctl_reg u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sdPin(sdPin), .fbPin(fbPin), .fbOe(fbOe), .intN(intN)
  );

  function automatic logic [7:0] expCtl();
    return {mEn, mIe, 4'b0000, mFb, mLvl};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic modelWrite(input logic [7:0] d);
    mEn = d[7]; mIe = d[6];
    mFb = mLvl ? d[1] : 1'b0;
  endtask

  task automatic checkAll(input string tag);
    logic [7:0] v;
    rdReg(REG_A, v);
    chk({tag, " R2/R4 ctl"}, v, expCtl());
    chk({tag, " R3 fbOe"}, {7'b0, fbOe}, {7'b0, mEn});
    chk({tag, " R3 fbPin"}, {7'b0, fbPin}, {7'b0, mEn & mFb});
    chk({tag, " R7 intN"}, {7'b0, intN}, {7'b0, ~mPend});
  endtask

  task automatic longToggle();
    @(negedge clk);
    sdPin = ~mLvl;
    repeat (12) @(negedge clk);
    mLvl = ~mLvl;
    if (!mLvl) mFb = 0;
    if (mIe) mPend = 1;
  endtask

  task automatic glitch(input int n);
    @(negedge clk);
    sdPin = ~mLvl;
    repeat (n) @(negedge clk);
    sdPin = mLvl;
    repeat (12) @(negedge clk);
  endtask

  task automatic readSrc(input string tag);
    logic [7:0] v;
    rdReg(SRC_A, v);
    chk({tag, " R8 src"}, v, mPend ? 8'h25 : 8'h00);
    mPend = 0;
    chk({tag, " R8 intN release"}, {7'b0, intN}, 8'h01);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0025);
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1 reset state
    checkAll("reset R1");
    rdReg(SRC_A, v);
    chk("reset R1 src", v, 8'h00);

    // R2 other address ignored, R4 bit0 write ignored
    wrReg(8'h24, 8'hFF);
    checkAll("other addr R2");
    wrReg(REG_A, 8'hFC);
    modelWrite(8'hFC);
    checkAll("bit0 write R4 R2");

    // R5 latency: enable, force bypass 1, interrupt on
    wrReg(REG_A, 8'hC2);
    modelWrite(8'hC2);
    @(negedge clk);
    sdPin = 0;
    repeat (5) @(negedge clk);
    chk("latency R5 still high", {7'b0, fbPin}, 8'h01);
    repeat (3) @(negedge clk);
    chk("latency R5 low by 8", {7'b0, fbPin}, 8'h00);
    repeat (4) @(negedge clk);
    mLvl = 0; mFb = 0; mPend = 1;
    checkAll("after loss R7");

    // R6 write 1 during low loses
    wrReg(REG_A, 8'hC2);
    modelWrite(8'hC2);
    checkAll("autoclr R6");
    readSrc("ack R8");

    // R4 glitch on low level
    glitch(3);
    checkAll("glitch R4");

    // R7 interrupt disabled: no interrupt on edge
    wrReg(REG_A, 8'h80);
    modelWrite(8'h80);
    longToggle();
    checkAll("no int R7");
    readSrc("no int src R7");

    // Random mix
    for (int i = 0; i < 80; i++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: begin
          v = 8'($urandom);
          wrReg(REG_A, v);
          modelWrite(v);
        end
        1: longToggle();
        2: glitch(1 + int'($urandom % 3));
        3: readSrc("rand R8");
        default: begin
          logic [7:0] a;
          a = 8'($urandom);
          if (a == REG_A) a = 8'h27;
          wrReg(a, 8'($urandom));
        end
      endcase
      checkAll("rand R6/R7");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule